// File: doc/BRIEF.md
# Touchscreen ADC oversampling scan sequencer

This block runs a full measurement scan of a serial 8-channel touchscreen converter over a four-wire SPI link, acting as the link master. Before a scan, software-side logic supplies an 8-bit channel-enable mask and two numbers for each channel: a settling-skip count and an oversampling ratio. A one-cycle `start` pulse launches the scan. The block visits the enabled channels from address 0 up to address 7. For each one it issues a burst of 24-bit frames, drops the leading settling results, sums the rest and divides the sum by the number of kept results, rounding up.

Every frame is a command byte followed by a 16-bit data word that the device returns while the master transmits zeros. All frames of a burst except the final one ask the device to keep its converter powered, so that the touch plates stay charged. The final frame of each burst clears both power-control bits, which lets the device power down and re-arm its pen-detect output. The averaged results are packed, lowest address first, into an eight-slot result buffer, and `done` pulses once when the scan ends.

Chip select stays low across the whole scan. The serial clock comes from a parameterised divider of the system clock.

Top module: `tscan_top`

## Requirements
- R1: After reset, `busy` and `done` are 0, `spiCsN` is 1, `spiSclk` is 0, `spiMosi` is 0 and every result slot reads 0.
- R2: Each frame has exactly 24 rising SCLK edges in SPI mode 0. SCLK idles low. MOSI is stable at every rising edge and carries the command byte MSB first, then 16 zero bits. `spiCsN` is low from the cycle after a scan starts until the cycle after `done`.
- R3: The command byte is {1, addr[2:0], 0, 0, 0, pwr}. Bit 7 is the start bit and bits 6:4 hold the channel address. Bits 3, 2 and 1 are 0. Bit 0 (`pwr`) is 1 on every frame of a channel except its last frame, where it is 0.
- R4: An enabled channel receives exactly skip + ratio frames. Results from the first `skip` frames are discarded.
- R5: The sample value is bits 14:3 of the received big-endian data word. Bit 15 and bits 2:0 have no effect on any result.
- R6: A channel's result is ceil(sum of kept samples / number of kept samples), zero-extended to 16 bits.
- R7: An oversampling ratio of 0 behaves exactly as a ratio of 1.
- R8: Results are written in ascending address order into slots 0, 1, 2 and so on. Slot k occupies `resData[16k+15:16k]`. Slots beyond the number of enabled channels read 0, because the buffer is cleared when a scan starts.
- R9: `busy` rises in the cycle after an accepted `start` and stays high until `done`. `done` is a single-cycle pulse during which `busy` is already low. A `start` pulse that arrives while `busy` is high is ignored.
- R10: With an all-zero enable mask, a scan produces no SCLK edges and still ends with a `done` pulse.
- R11: A skip count of 0 keeps every frame of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle scan request |
| chanEn | input | 8 | Channel-enable mask, bit n is address n |
| skipCnt | input | 64 | Settling-skip count per channel, channel n in bits 8n+7:8n |
| osRatio | input | 64 | Oversampling ratio per channel, channel n in bits 8n+7:8n |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| resData | output | 128 | Packed result buffer, slot k in bits 16k+15:16k |
| spiSclk | output | 1 | Serial clock, idle low |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Master data out |
| spiMiso | input | 1 | Master data in |

## Verification
The embedded assertions check the following on every cycle:
- SCLK stays low whenever chip select is released, and no frame runs without chip select.
- Every command issued carries the start bit and zero mode bits.
- A frame is never launched on top of another frame, and a burst never goes beyond its frame total.
- An averaged result never exceeds the 12-bit range.
- `done` is a lone pulse that follows `busy`.

Only the bench's scenarios can show the following, because each needs a device model and a reference sum:
- The per-frame power bit pattern.
- The frame count of each burst.
- The discarding of settling frames.
- The masking of the data word's outer bits.
- Correct round-up division.
- Result packing order.
- Ratio-0 handling.
- The empty-mask scan.
- Rejection of a start pulse in mid-scan.

// File: rtl/tscan_pkg.sv
package tscan_pkg;
  localparam int ADDR_W     = 3;
  localparam int NUM_CH     = 1 << ADDR_W;
  localparam int SAMP_W     = 12;
  localparam int RES_W      = 16;
  localparam int FRAME_BITS = 24;
  localparam int CMD_W      = 8;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic              csOn;
    logic              bufClr;
    logic              frameGo;
    logic [CMD_W-1:0]  cmd;
    logic              accClr;
    logic              accAdd;
    logic              divGo;
    logic              resWr;
    logic [ADDR_W-1:0] resSlot;
  } ctrl_strobe_t;
endpackage

// File: rtl/tscan_dpath.sv
module tscan_dpath
  import tscan_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int HALF_DIV = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_strobe_t            ctl,
  input  logic [CNT_W-1:0]        keepN,
  input  logic                    spiMiso,
  output logic                    spiSclk,
  output logic                    spiCsN,
  output logic                    spiMosi,
  output logic                    frameBusy,
  output logic                    frameDone,
  output logic                    divDone,
  output logic [NUM_CH*RES_W-1:0] resData
);
  localparam int DIV_CW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_CW  = $clog2(FRAME_BITS + 1);
  localparam int SUM_W   = SAMP_W + CNT_W;
  localparam int NUM_W   = SUM_W + 1;
  localparam int STEP_W  = $clog2(NUM_W + 1);
  localparam logic [DIV_CW-1:0] DIV_LAST = DIV_CW'(HALF_DIV - 1);
  localparam logic [BIT_CW-1:0] BITS_END = BIT_CW'(FRAME_BITS);
  // data bits 14..3 arrive on rising edges 10..21 (bit count 9..20 before increment)
  localparam logic [BIT_CW-1:0] CAP_LO   = BIT_CW'(CMD_W + 1);
  localparam logic [BIT_CW-1:0] CAP_HI   = BIT_CW'(CMD_W + SAMP_W);

  logic [DIV_CW-1:0]     divCnt;
  logic [BIT_CW-1:0]     bitCnt;
  logic [FRAME_BITS-1:0] txSh;
  logic [SAMP_W-1:0]     rxSh;
  logic                  sclkQ;
  logic                  tick;

  assign tick = (divCnt == DIV_LAST);

  // ---------------- serial frame engine ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      bitCnt    <= '0;
      txSh      <= '0;
      rxSh      <= '0;
      sclkQ     <= 1'b0;
      frameBusy <= 1'b0;
      frameDone <= 1'b0;
      spiCsN    <= 1'b1;
    end else begin
      frameDone <= 1'b0;
      spiCsN    <= ~ctl.csOn;
      if (ctl.frameGo) begin
        txSh      <= {ctl.cmd, {(FRAME_BITS-CMD_W){1'b0}}};
        frameBusy <= 1'b1;
        divCnt    <= '0;
        bitCnt    <= '0;
        sclkQ     <= 1'b0;
      end else if (frameBusy) begin
        if (tick) begin
          divCnt <= '0;
          if (!sclkQ) begin
            sclkQ  <= 1'b1;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt >= CAP_LO && bitCnt <= CAP_HI)
              rxSh <= {rxSh[SAMP_W-2:0], spiMiso};
          end else begin
            sclkQ <= 1'b0;
            if (bitCnt == BITS_END) begin
              frameBusy <= 1'b0;
              frameDone <= 1'b1;
            end else begin
              txSh <= {txSh[FRAME_BITS-2:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign spiSclk = sclkQ;
  assign spiMosi = frameBusy & txSh[FRAME_BITS-1];

  // ---------------- accumulator ----------------
  logic [SUM_W-1:0] acc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           acc <= '0;
    else if (ctl.accClr) acc <= '0;
    else if (ctl.accAdd) acc <= acc + SUM_W'(rxSh);
  end

  // ---------------- round-up restoring divider ----------------
  logic [NUM_W-1:0]  divNum;
  logic [CNT_W-1:0]  divRem;
  logic [STEP_W-1:0] divStep;
  logic [CNT_W:0]    trial;
  logic              fits;

  assign trial = {divRem, divNum[NUM_W-1]};
  assign fits  = (trial >= {1'b0, keepN});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divNum  <= '0;
      divRem  <= '0;
      divStep <= '0;
      divDone <= 1'b0;
    end else begin
      divDone <= 1'b0;
      if (ctl.divGo) begin
        divNum  <= NUM_W'(acc) + NUM_W'(keepN) - NUM_W'(1);
        divRem  <= '0;
        divStep <= STEP_W'(NUM_W);
      end else if (divStep != '0) begin
        divRem  <= fits ? CNT_W'(trial - {1'b0, keepN}) : CNT_W'(trial);
        divNum  <= {divNum[NUM_W-2:0], fits};
        divStep <= divStep - 1'b1;
        if (divStep == STEP_W'(1)) divDone <= 1'b1;
      end
    end
  end

  // ---------------- result buffer ----------------
  logic [RES_W-1:0] resBuf [NUM_CH];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) resBuf[i] <= '0;
    end else if (ctl.bufClr) begin
      for (int i = 0; i < NUM_CH; i++) resBuf[i] <= '0;
    end else if (ctl.resWr) begin
      resBuf[ctl.resSlot] <= RES_W'(divNum);
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_pack
    assign resData[k*RES_W +: RES_W] = resBuf[k];
  end

  // ---------------- assertions ----------------
  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);
  a_r2_frame_under_cs: assert property (@(posedge clk) disable iff (!rstN)
    frameBusy |-> !spiCsN);
  a_r2_go_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frameGo |-> !frameBusy);
  a_r3_cmd_fields: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frameGo |-> (ctl.cmd[7] && ctl.cmd[3:1] == 3'b000));
  a_r6_avg_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.resWr |-> (divNum < NUM_W'(1 << SAMP_W)));
endmodule

// File: rtl/tscan_ctrl.sv
module tscan_ctrl
  import tscan_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [NUM_CH-1:0]       chanEn,
  input  logic [NUM_CH*CNT_W-1:0] skipFlat,
  input  logic [NUM_CH*CNT_W-1:0] ratioFlat,
  input  logic                    frameDone,
  input  logic                    divDone,
  output ctrl_strobe_t            ctl,
  output logic [CNT_W-1:0]        keepN,
  output logic                    busy,
  output logic                    done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEEK, ST_SEND, ST_WAITF, ST_ACC, ST_DIVS, ST_DIVW, ST_FIN
  } state_t;

  state_t            state;
  logic [NUM_CH-1:0] maskQ;
  logic [ADDR_W:0]   chIdx;
  logic [ADDR_W-1:0] slot;
  logic [CNT_W:0]    frmIdx;
  logic [CNT_W-1:0]  skipCur;
  logic [CNT_W-1:0]  keepCur;
  logic [CNT_W:0]    frmTotal;
  logic              lastFrm;
  logic              keepFrm;
  logic              chSel;
  logic              pastEnd;
  logic [CNT_W-1:0]  skipSel;
  logic [CNT_W-1:0]  ratioSel;

  assign pastEnd  = chIdx[ADDR_W];
  assign chSel    = !pastEnd && maskQ[chIdx[ADDR_W-1:0]];
  assign skipSel  = skipFlat[chIdx[ADDR_W-1:0]*CNT_W +: CNT_W];
  assign ratioSel = ratioFlat[chIdx[ADDR_W-1:0]*CNT_W +: CNT_W];
  assign frmTotal = {1'b0, skipCur} + {1'b0, keepCur};
  assign lastFrm  = (frmIdx == frmTotal - 1'b1);
  assign keepFrm  = (frmIdx >= {1'b0, skipCur});
  assign keepN    = keepCur;
  assign busy     = (state != ST_IDLE) && (state != ST_FIN);
  assign done     = (state == ST_FIN);

  always_comb begin
    ctl         = '0;
    ctl.csOn    = busy;
    ctl.cmd     = {1'b1, chIdx[ADDR_W-1:0], 3'b000, ~lastFrm};
    ctl.resSlot = slot;
    case (state)
      ST_IDLE:  ctl.bufClr  = start;
      ST_SEEK:  ctl.accClr  = chSel;
      ST_SEND:  ctl.frameGo = 1'b1;
      ST_ACC:   ctl.accAdd  = keepFrm;
      ST_DIVS:  ctl.divGo   = 1'b1;
      ST_DIVW:  ctl.resWr   = divDone;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      maskQ   <= '0;
      chIdx   <= '0;
      slot    <= '0;
      frmIdx  <= '0;
      skipCur <= '0;
      keepCur <= CNT_W'(1);
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          maskQ <= chanEn;
          chIdx <= '0;
          slot  <= '0;
          state <= ST_SEEK;
        end
        ST_SEEK: begin
          if (pastEnd) state <= ST_FIN;
          else if (chSel) begin
            skipCur <= skipSel;
            keepCur <= (ratioSel == '0) ? CNT_W'(1) : ratioSel;
            frmIdx  <= '0;
            state   <= ST_SEND;
          end else chIdx <= chIdx + 1'b1;
        end
        ST_SEND:  state <= ST_WAITF;
        ST_WAITF: if (frameDone) state <= ST_ACC;
        ST_ACC: begin
          if (lastFrm) state <= ST_DIVS;
          else begin
            frmIdx <= frmIdx + 1'b1;
            state  <= ST_SEND;
          end
        end
        ST_DIVS: state <= ST_DIVW;
        ST_DIVW: if (divDone) begin
          slot  <= slot + 1'b1;
          chIdx <= chIdx + 1'b1;
          state <= ST_SEEK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
  a_r4_frame_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) |-> (frmIdx < frmTotal));
  a_r7_keep_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) |-> (keepCur != '0));
  a_r8_slot_order: assert property (@(posedge clk) disable iff (!rstN)
    ctl.resWr |-> ({1'b0, slot} <= chIdx));
endmodule

// File: rtl/tscan_top.sv
module tscan_top
  import tscan_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int HALF_DIV = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [NUM_CH-1:0]       chanEn,
  input  logic [NUM_CH*CNT_W-1:0] skipCnt,
  input  logic [NUM_CH*CNT_W-1:0] osRatio,
  output logic                    busy,
  output logic                    done,
  output logic [NUM_CH*RES_W-1:0] resData,
  output logic                    spiSclk,
  output logic                    spiCsN,
  output logic                    spiMosi,
  input  logic                    spiMiso
);
  ctrl_strobe_t     ctl;
  logic [CNT_W-1:0] keepN;
  logic             frameBusy;
  logic             frameDone;
  logic             divDone;

  tscan_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .chanEn(chanEn),
    .skipFlat(skipCnt), .ratioFlat(osRatio),
    .frameDone(frameDone), .divDone(divDone),
    .ctl(ctl), .keepN(keepN), .busy(busy), .done(done)
  );

  tscan_dpath #(.CNT_W(CNT_W), .HALF_DIV(HALF_DIV)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .keepN(keepN), .spiMiso(spiMiso),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .frameBusy(frameBusy), .frameDone(frameDone), .divDone(divDone),
    .resData(resData)
  );

  a_r2_cs_released: assert property (@(posedge clk) disable iff (!rstN)
    done |=> spiCsN);
  a_r2_cs_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !spiCsN);
endmodule

// File: tb/sim_tscan_top.sv
module sim_tscan_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] chanEn = '0;
  logic [7:0] skipArr [8];
  logic [7:0] ratioArr [8];
  logic [63:0] skipCnt, osRatio;
  logic busy, done, spiSclk, spiCsN, spiMosi;
  logic spiMiso = 1'b0;
  logic [127:0] resData;

  for (genvar k = 0; k < 8; k++) begin : g_cfg
    assign skipCnt[k*8 +: 8] = skipArr[k];
    assign osRatio[k*8 +: 8] = ratioArr[k];
  end

  always #2.5 clk = ~clk;

  tscan_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .chanEn(chanEn),
    .skipCnt(skipCnt), .osRatio(osRatio), .busy(busy), .done(done),
    .resData(resData), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int nChk = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [7:0]  cmdLog [1024];
  logic [7:0]  cmdSh = '0;
  logic [15:0] curWord = '0;
  int bitPos = 0;
  int frameNo = 0;
  int sclkRises = 0;
  int mosiErr = 0;

  function automatic logic [11:0] mkVal(input int g, input logic [2:0] a);
    int v;
    v = g * 397 + int'(a) * 211 + 5;
    return v[11:0];
  endfunction

  always @(posedge spiSclk) begin
    if (!spiCsN) begin
      sclkRises++;
      if (bitPos < 8) begin
        cmdSh = {cmdSh[6:0], spiMosi};
        if (bitPos == 7) begin
          if (frameNo < 1024) cmdLog[frameNo] = cmdSh;
          // bit15 and bits 2:0 set to junk ones (R5)
          curWord = {1'b1, mkVal(frameNo, cmdSh[6:4]), 3'b111};
        end
      end else if (spiMosi) begin
        mosiErr++;
      end
      bitPos++;
      if (bitPos == 24) begin
        bitPos = 0;
        frameNo++;
      end
    end
  end

  always @(negedge spiSclk) begin
    if (!spiCsN && bitPos >= 8) spiMiso = curWord[23 - bitPos];
  end

  always @(posedge spiCsN) bitPos = 0;

  // ---------------- scan runner with reference model ----------------
  task automatic run_scan(input logic [7:0] mask, input bit midStart, input string name);
    int g, s, tot, r, sum, expv, waitN;
    logic [7:0] expCmd;
    frameNo = 0; sclkRises = 0; mosiErr = 0; bitPos = 0;
    chanEn = mask;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, {name, " R9 busy after start"}, busy, 1);
    if (midStart) begin
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    waitN = 0;
    while (done !== 1'b1 && waitN < 60000) begin
      @(negedge clk);
      waitN++;
    end
    chk(done === 1'b1, {name, " R9 done seen"}, done, 1);
    chk(busy === 1'b0, {name, " R9 busy low at done"}, busy, 0);
    @(negedge clk);
    chk(done === 1'b0, {name, " R9 done single pulse"}, done, 0);
    chk(spiCsN === 1'b1, {name, " R2 cs released after done"}, spiCsN, 1);
    // reference
    g = 0; s = 0;
    for (int ch = 0; ch < 8; ch++) begin
      if (mask[ch]) begin
        r = (ratioArr[ch] == 0) ? 1 : int'(ratioArr[ch]);   // R7
        tot = int'(skipArr[ch]) + r;                          // R4
        sum = 0;
        for (int f = 0; f < tot; f++) begin
          expCmd = {1'b1, 3'(ch), 3'b000, (f != tot - 1)};     // R3
          chk(cmdLog[g] === expCmd, {name, " R3 command byte"}, int'(cmdLog[g]), int'(expCmd));
          if (f >= int'(skipArr[ch])) sum += int'(mkVal(g, 3'(ch)));  // R11 skip 0 keeps all
          g++;
        end
        expv = (sum + r - 1) / r;                             // R6
        chk(int'(resData[s*16 +: 16]) == expv, {name, " R6 averaged slot"},
            int'(resData[s*16 +: 16]), expv);
        s++;
      end
    end
    for (int k = s; k < 8; k++)
      chk(resData[k*16 +: 16] === 16'h0, {name, " R8 unused slot zero"},
          int'(resData[k*16 +: 16]), 0);
    chk(frameNo == g, {name, " R4 frame count"}, frameNo, g);
    chk(sclkRises == 24 * g, {name, " R2 sclk edges"}, sclkRises, 24 * g);
    chk(mosiErr == 0, {name, " R2 zero data bits"}, mosiErr, 0);
    if (midStart) begin
      repeat (100) @(negedge clk);
      chk(busy === 1'b0, {name, " R9 mid-scan start ignored"}, busy, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(spiCsN === 1'b1, "R1 csN", spiCsN, 1);
    chk(spiSclk === 1'b0, "R1 sclk", spiSclk, 0);
    chk(spiMosi === 1'b0, "R1 mosi", spiMosi, 0);
    chk(resData === '0, "R1 results", 0, 0);
  endtask

  task automatic t_defaults;
    for (int k = 0; k < 8; k++) begin skipArr[k] = 8'd1; ratioArr[k] = 8'd1; end
    run_scan(8'hFF, 1'b0, "defaults R5");
  endtask

  task automatic t_oversample;
    skipArr[1] = 0; ratioArr[1] = 4;
    skipArr[2] = 3; ratioArr[2] = 3;
    skipArr[5] = 2; ratioArr[5] = 5;
    skipArr[7] = 1; ratioArr[7] = 7;
    run_scan(8'hA6, 1'b0, "oversample R11");
  endtask

  task automatic t_ratio_zero;
    skipArr[0] = 2; ratioArr[0] = 0;
    skipArr[3] = 0; ratioArr[3] = 0;
    run_scan(8'h09, 1'b0, "ratio0 R7");
  endtask

  task automatic t_pack_clear;
    skipArr[0] = 1; ratioArr[0] = 2;
    skipArr[7] = 0; ratioArr[7] = 3;
    run_scan(8'h81, 1'b0, "pack R8");
  endtask

  task automatic t_empty;
    run_scan(8'h00, 1'b0, "empty R10");
  endtask

  task automatic t_busy_start;
    skipArr[4] = 1; ratioArr[4] = 2;
    skipArr[5] = 0; ratioArr[5] = 2;
    run_scan(8'h30, 1'b1, "midstart R9");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin skipArr[k] = 8'd1; ratioArr[k] = 8'd1; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_defaults();
    t_oversample();
    t_ratio_zero();
    t_pack_clear();
    t_empty();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule